// File: doc/BRIEF.md
# Programmable Polling Bus Arbiter

This block hands a shared bus to one of several devices. It uses no per-device grant wires. Every device that wants the bus drives a common wired-OR request line. The arbiter answers by putting device addresses, one after another, on a set of poll-count lines. Each device cell holds a fixed address of its own and watches those lines. When the broadcast address is its own and it is requesting, it claims the bus. The claim is shown as a grant bit and as the shared busy line.

The addresses are not wired in a fixed order. They come from a small table that software loads through a plain register-write port, together with the index of the last valid entry. A device's priority is therefore the position of its address in that table. Polling always starts again from entry 0 once the bus is idle, so for requests raised together from idle, the requester that appears first in the table wins.

A slot whose address gets no answer costs exactly one cycle. This covers a device that is not requesting, a dead device and an address that no device holds. So no single device can stall arbitration. While a device owns the bus the poll count is held. The device keeps the bus for as long as it keeps its request high.

Top module: `poll_bus_arbiter`

## Requirements
- R1: `busReq` equals the OR of all bits of `devReq` in the same cycle.
- R2: After reset the table entry k holds address k, the last valid index is DEPTH-1, the entry pointer is 0 and no grant is active. In any cycle with no request and no owner, the pointer returns to entry 0 at the next edge.
- R3: `pollCount` always shows the table entry under the pointer. While `busReq` is high, no device owns the bus and no device claims, the pointer moves one entry per clock.
- R4: When the pointer is at or beyond the programmed last index and would advance, it goes to entry 0 instead.
- R5: Device i has address i. In a cycle where `pollCount` equals i, `devReq[i]` is high and the bus is not owned, bit i of `grant` and `busBusy` become high at the next edge.
- R6: For requests raised together from an idle bus, the device granted is the requester whose address appears first in table order between entry 0 and the last index.
- R7: While `busBusy` is high, the pointer and `pollCount` hold, unless the table is written. The owner keeps its grant while its request stays high, and loses it at the edge after its request falls.
- R8: When `cfgWrEn` is high, table entry `cfgWrIdx` takes `cfgWrData` at the clock edge. When `cfgLastWrEn` is high, the last valid index takes `cfgLastData`.
- R9: A polled address whose device is not requesting, or that no device holds (values N and above), is passed after exactly one cycle. A requester that is absent from the active part of the table is never granted.
- R10: At most one bit of `grant` is high at any time, and `busBusy` is the OR of `grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | N | Per-device bus request |
| cfgWrEn | input | 1 | Write strobe for one poll table entry |
| cfgWrIdx | input | IDXW | Table entry to write |
| cfgWrData | input | ADDRW | Device address to store |
| cfgLastWrEn | input | 1 | Write strobe for the last valid index |
| cfgLastData | input | IDXW | New last valid index |
| busReq | output | 1 | Shared wired-OR request line |
| pollCount | output | ADDRW | Address currently broadcast on the poll-count lines |
| busBusy | output | 1 | Bus owned by a device |
| grant | output | N | One-hot owner indication |

## Verification
The hardest situation to reach from the ports is a table rewrite that lands while a device owns the bus or while a sweep is part-way through. The worst case is the last index being lowered below the current pointer, which must still wrap rather than run off the end. The bench loads several orders, some of which contain unheld addresses and short lengths. It then checks the first requester in table order. A long random phase toggles requests and interleaves table and length writes on any cycle, against a behavioural reference model that is compared on every clock.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  // Strobes from the poll controller to the sequence datapath.
  typedef struct packed {
    logic restart;  // go back to entry 0 (bus idle)
    logic step;     // move to the next entry
    logic wrap;     // move to entry 0 after the last valid one
  } pollStrobe_t;
endpackage

// File: rtl/poll_seq_datapath.sv
module poll_seq_datapath
  import poll_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ADDRW = 3,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pollStrobe_t      strobe,
  input  logic             cfgWrEn,
  input  logic [IDXW-1:0]  cfgWrIdx,
  input  logic [ADDRW-1:0] cfgWrData,
  input  logic             cfgLastWrEn,
  input  logic [IDXW-1:0]  cfgLastData,
  output logic [ADDRW-1:0] pollCount,
  output logic             atLast
);
  logic [ADDRW-1:0] seqTab [DEPTH];
  logic [IDXW-1:0]  entryPtr;
  logic [IDXW-1:0]  lastIdx;

  // Sequence table: one register per entry, loaded from the write port.
  generate
    for (genvar k = 0; k < DEPTH; k++) begin : gEntry
      always_ff @(posedge clk) begin
        if (!rstN)
          seqTab[k] <= ADDRW'(k);
        else if (cfgWrEn && (cfgWrIdx == IDXW'(k)))
          seqTab[k] <= cfgWrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      lastIdx <= IDXW'(DEPTH - 1);
    else if (cfgLastWrEn)
      lastIdx <= cfgLastData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      entryPtr <= '0;
    else if (strobe.restart || strobe.wrap)
      entryPtr <= '0;
    else if (strobe.step)
      entryPtr <= entryPtr + IDXW'(1);
  end

  assign atLast    = (entryPtr >= lastIdx);
  assign pollCount = seqTab[entryPtr];
endmodule

// File: rtl/poll_seq_control.sv
module poll_seq_control
  import poll_arb_pkg::*;
(
  input  logic        busReq,
  input  logic        busBusy,
  input  logic        claimNow,
  input  logic        atLast,
  output pollStrobe_t strobe,
  output logic        pollActive
);
  logic moveOn;

  always_comb begin
    pollActive     = busReq && !busBusy;
    // A slot with no answer is left after one cycle.
    moveOn         = pollActive && !claimNow;
    strobe.restart = !busReq && !busBusy;
    strobe.wrap    = moveOn && atLast;
    strobe.step    = moveOn && !atLast;
  end
endmodule

// File: rtl/poll_device_cell.sv
module poll_device_cell #(
  parameter int ADDRW   = 3,
  parameter int MY_ADDR = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wantBus,
  input  logic             pollActive,
  input  logic [ADDRW-1:0] pollCount,
  output logic             hit,
  output logic             owner
);
  assign hit = wantBus && pollActive && (pollCount == ADDRW'(MY_ADDR));

  always_ff @(posedge clk) begin
    if (!rstN)
      owner <= 1'b0;
    else if (owner)
      owner <= wantBus;
    else
      owner <= hit;
  end
endmodule

// File: rtl/poll_bus_arbiter.sv
module poll_bus_arbiter
  import poll_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int ADDRW = $clog2(N) + 1,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     devReq,
  input  logic             cfgWrEn,
  input  logic [IDXW-1:0]  cfgWrIdx,
  input  logic [ADDRW-1:0] cfgWrData,
  input  logic             cfgLastWrEn,
  input  logic [IDXW-1:0]  cfgLastData,
  output logic             busReq,
  output logic [ADDRW-1:0] pollCount,
  output logic             busBusy,
  output logic [N-1:0]     grant
);
  pollStrobe_t strobe;
  logic        pollActive;
  logic        atLast;
  logic [N-1:0] hitVec;

  assign busReq  = |devReq;
  assign busBusy = |grant;

  poll_seq_control uCtrl (
    .busReq    (busReq),
    .busBusy   (busBusy),
    .claimNow  (|hitVec),
    .atLast    (atLast),
    .strobe    (strobe),
    .pollActive(pollActive)
  );

  poll_seq_datapath #(.DEPTH(DEPTH), .ADDRW(ADDRW)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrEn    (cfgWrEn),
    .cfgWrIdx   (cfgWrIdx),
    .cfgWrData  (cfgWrData),
    .cfgLastWrEn(cfgLastWrEn),
    .cfgLastData(cfgLastData),
    .pollCount  (pollCount),
    .atLast     (atLast)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : gDev
      poll_device_cell #(.ADDRW(ADDRW), .MY_ADDR(i)) uCell (
        .clk       (clk),
        .rstN      (rstN),
        .wantBus   (devReq[i]),
        .pollActive(pollActive),
        .pollCount (pollCount),
        .hit       (hitVec[i]),
        .owner     (grant[i])
      );
    end
  endgenerate
endmodule

// File: rtl/poll_bus_arbiter_checks.sv
module poll_bus_arbiter_checks #(
  parameter int N     = 4,
  parameter int ADDRW = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     devReq,
  input logic             cfgWrEn,
  input logic             busReq,
  input logic [ADDRW-1:0] pollCount,
  input logic             busBusy,
  input logic [N-1:0]     grant
);
  assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_busy_is_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    busBusy == (grant != '0));

  assert_req_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    busReq == (devReq != '0));

  assert_hold_poll_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && !cfgWrEn) |=> $stable(pollCount));

  assert_idle_no_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busReq && !busBusy) |=> !busBusy);

  assert_claim_matches_poll_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> (grant == (N'(1) << $past(pollCount))));

  generate
    for (genvar i = 0; i < N; i++) begin : gRel
      assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
        (grant[i] && !devReq[i]) |=> !grant[i]);
    end
  endgenerate
endmodule

bind poll_bus_arbiter poll_bus_arbiter_checks #(.N(N), .ADDRW(ADDRW)) uChecks (
  .clk      (clk),
  .rstN     (rstN),
  .devReq   (devReq),
  .cfgWrEn  (cfgWrEn),
  .busReq   (busReq),
  .pollCount(pollCount),
  .busBusy  (busBusy),
  .grant    (grant)
);

// File: tb/poll_bus_arbiter_test.sv
module poll_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int DEPTH = 8;
  localparam int ADDRW = 3;
  localparam int IDXW = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [N-1:0]     devReq = '0;
  logic             cfgWrEn = 1'b0;
  logic [IDXW-1:0]  cfgWrIdx = '0;
  logic [ADDRW-1:0] cfgWrData = '0;
  logic             cfgLastWrEn = 1'b0;
  logic [IDXW-1:0]  cfgLastData = '0;
  logic             busReq;
  logic [ADDRW-1:0] pollCount;
  logic             busBusy;
  logic [N-1:0]     grant;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state.
  int mTab[DEPTH];
  int mPtr;
  int mLast;
  int mOwner;

  always #(CLK_PERIOD/2) clk = ~clk;

  poll_bus_arbiter #(.N(N), .DEPTH(DEPTH), .ADDRW(ADDRW)) uut (
    .clk(clk), .rstN(rstN), .devReq(devReq),
    .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData),
    .cfgLastWrEn(cfgLastWrEn), .cfgLastData(cfgLastData),
    .busReq(busReq), .pollCount(pollCount), .busBusy(busBusy), .grant(grant)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cycles);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < DEPTH; k++) mTab[k] = k;
    mPtr = 0;
    mLast = DEPTH - 1;
    mOwner = -1;
  endtask

  // Compare ports with the model, then advance one clock.
  task automatic step();
    int expPoll, expGrant, claim;
    bit expBusy, expReq;
    #1;
    expPoll  = mTab[mPtr];
    expBusy  = (mOwner >= 0);
    expReq   = (devReq != '0);
    expGrant = expBusy ? (1 << mOwner) : 0;
    check(busReq == expReq, "R1 busReq", busReq, expReq);
    check(int'(pollCount) == expPoll, "R3 pollCount", pollCount, expPoll);
    check(busBusy == expBusy, "R10 busBusy", busBusy, expBusy);
    check(int'(grant) == expGrant, "R5 grant", grant, expGrant);
    claim = -1;
    if (!expBusy && expReq && expPoll < N && devReq[expPoll]) claim = expPoll;
    @(posedge clk);
    cycles++;
    if (mOwner >= 0) begin
      if (!devReq[mOwner]) mOwner = -1;
    end else if (claim >= 0) mOwner = claim;
    if (!expBusy) begin
      if (!expReq) mPtr = 0;
      else if (claim < 0) mPtr = (mPtr >= mLast) ? 0 : mPtr + 1;
    end
    if (cfgWrEn) mTab[cfgWrIdx] = cfgWrData;
    if (cfgLastWrEn) mLast = cfgLastData;
    @(negedge clk);
  endtask

  task automatic writeEntry(input int idx, input int addr);
    cfgWrEn = 1'b1; cfgWrIdx = IDXW'(idx); cfgWrData = ADDRW'(addr);
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic writeLast(input int last);
    cfgLastWrEn = 1'b1; cfgLastData = IDXW'(last);
    step();
    cfgLastWrEn = 1'b0;
  endtask

  function automatic int firstInSeq(input logic [N-1:0] mask);
    for (int k = 0; k <= mLast; k++)
      if (mTab[k] < N && mask[mTab[k]]) return mTab[k];
    return -1;
  endfunction

  // R6: from idle, raise a set of requests and check the winner.
  task automatic arbitrate(input logic [N-1:0] mask, input string tag);
    int win, waitCnt;
    win = firstInSeq(mask);
    devReq = mask;
    waitCnt = 0;
    while (!busBusy && waitCnt < 3 * DEPTH) begin
      step();
      waitCnt++;
    end
    #1;
    check(int'(grant) == ((win >= 0) ? (1 << win) : 0), tag, grant,
          (win >= 0) ? (1 << win) : 0);
    devReq = '0;
    step(); step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R2: reset state seen at the ports.
    check(grant == '0, "R2 no grant after reset", grant, 0);
    check(pollCount == '0, "R2 pollCount entry0 after reset", pollCount, 0);
    step(); step();

    // R3 / R5: single requester with identity table, device 2 at slot 2.
    devReq = 4'b0100;
    step(); step();
    #1;
    check(pollCount == 3'd2 && !busBusy, "R3 one slot per cycle", pollCount, 2);
    step();
    #1;
    check(grant == 4'b0100, "R5 device 2 owns", grant, 4);
    // R7: hold while owned.
    step(); step();
    check(pollCount == 3'd2, "R7 poll frozen while busy", pollCount, 2);
    devReq = '0;
    step();
    #1;
    check(grant == '0, "R7 release after request drops", grant, 0);
    step();

    // R6 / R8: program order 3,1,0,2 and last index 3.
    writeEntry(0, 3); writeEntry(1, 1); writeEntry(2, 0); writeEntry(3, 2);
    writeLast(3);
    arbitrate(4'b0101, "R6 order 3102 mask 0101");
    arbitrate(4'b0110, "R6 order 3102 mask 0110");
    arbitrate(4'b1111, "R6 order 3102 all request");

    // R9: unheld addresses first, then device 1; order 6,7,1,0.
    writeEntry(0, 6); writeEntry(1, 7); writeEntry(2, 1); writeEntry(3, 0);
    arbitrate(4'b0011, "R9 unheld addresses skipped");

    // R4 / R9: short table 5,2 that never names device 3.
    writeEntry(0, 5); writeEntry(1, 2); writeLast(1);
    devReq = 4'b1000;
    for (int c = 0; c < 6; c++) step();
    #1;
    check(!busBusy, "R9 absent requester never granted", busBusy, 0);
    check(pollCount == 3'd5 || pollCount == 3'd2, "R4 wraps within two entries",
          pollCount, 5);
    devReq = '0;
    step(); step();

    // R4: lower last index below the pointer mid-sweep.
    writeLast(7);
    for (int k = 0; k < DEPTH; k++) writeEntry(k, 4 + (k % 4));
    devReq = 4'b0001;
    for (int c = 0; c < 5; c++) step();
    writeLast(1);
    step();
    #1;
    check(pollCount == 3'd4, "R4 wrap when pointer beyond last", pollCount, 4);
    devReq = '0;
    step(); step();

    // Random phase with writes on any cycle.
    writeLast(DEPTH - 1);
    for (int k = 0; k < DEPTH; k++) writeEntry(k, k);
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) devReq = N'($urandom());
      cfgWrEn = ($urandom_range(0, 9) == 0);
      cfgWrIdx = IDXW'($urandom());
      cfgWrData = ADDRW'($urandom());
      cfgLastWrEn = ($urandom_range(0, 29) == 0);
      cfgLastData = IDXW'($urandom());
      step();
    end
    cfgWrEn = 1'b0; cfgLastWrEn = 1'b0; devReq = '0;
    step(); step();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule